// File: doc/BRIEF.md
# Interrupt Flag and Mask Unit

This unit collects single-cycle event pulses from five interrupt sources and turns them into one level interrupt request for a processor. The sources are timer A underflow, timer B underflow, the time-of-day alarm, the serial port and an external flag input. Every event is latched into a flag bit whether or not its source is enabled. A mask register decides which latched events raise the request.

The processor reaches the unit through one byte-wide register on a small register bus. A read returns the latched flags together with a summary bit. The same read clears the flags and drops the request. A write changes the mask: data bit 7 selects whether the remaining bits set or clear mask bits. The unit sits beside the sources and the processor and contains neither of them.

Top module: `icr_unit`

## Requirements
- R1: A pulse on `src_evt[i]` sets flag bit i on the next clock edge, whatever the mask holds. The bit positions are timer A 0, timer B 1, alarm 2, serial 3, external 4.
- R2: If mask bit i is set when an event on source i arrives, the summary bit (bit 7) and `irq` are 1 from the following cycle.
- R3: A register write whose data bit 7 is 1 ORs data bits 6:0 into the mask.
- R4: A register write whose data bit 7 is 0 clears every mask bit whose data bit is 1. It leaves the other mask bits unchanged.
- R5: After a write that sets mask bits, the summary bit and `irq` rise in the next cycle if any of flags 4:0 is both latched and enabled. Latched includes an event arriving in that same cycle.
- R6: A register read returns `{summary, 2'b00, flags[4:0]}` on `bus_rdata` in the same cycle. From the next cycle on, all flags are cleared and `irq` is low.
- R7: An event that arrives in the same cycle as a read is not lost. Its flag is set after the clear, and if its mask bit is set the summary bit and `irq` are set after the clear too.
- R8: Once asserted, `irq` stays high until a register read. Later events and mask-clearing writes do not drop it.
- R9: Reset clears the flags, the mask and `irq`.
- R10: An access with `bus_sel` low, or to an address other than 0xD, changes neither the flags nor the mask. `bus_rdata` is 0 whenever no read of the register is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | 5 | One-cycle event pulses: bit 0 timer A, 1 timer B, 2 alarm, 3 serial, 4 external |
| bus_sel | input | 1 | Register bus select |
| bus_addr | input | 4 | Register address; the unit answers at 0xD |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: summary in bit 7, flags in bits 4:0 |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the unit with its default parameters: five sources, an 8-bit data path and register address 0xD. With these values every source bit and both stored-only mask bits 6:5 are reachable, and so are the two read bits that always return zero. The same build lets the bench hit the unanswered neighbour address 0xC. A behavioural model runs next to the design and is compared every cycle. It checks the cases where an event meets a read, and where a pending flag is enabled by a later mask write. Pseudo-random traffic then mixes events, reads and set and clear writes.

// File: rtl/icr_pkg.sv
package icr_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_SET  = 2'd2,
    ACC_CLR  = 2'd3
  } acc_t;
endpackage

// File: rtl/icr_decode.sv
module icr_decode
  import icr_pkg::*;
#(
  parameter int AW       = 4,
  parameter int REG_ADDR = 13
) (
  input  logic          bus_sel,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          wr_mode,
  output acc_t          acc
);
  logic addr_hit;
  assign addr_hit = bus_sel && (bus_addr == AW'(REG_ADDR));

  // A read wins over a write strobe raised in the same cycle.
  always_comb begin
    acc = ACC_NONE;
    if (addr_hit && bus_rd)      acc = ACC_RD;
    else if (addr_hit && bus_wr) acc = wr_mode ? ACC_SET : ACC_CLR;
  end
endmodule

// File: rtl/icr_mask.sv
module icr_mask
  import icr_pkg::*;
#(
  parameter int MW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_t          acc,
  input  logic [MW-1:0] wbits,
  output logic [MW-1:0] mask_q,
  output logic [MW-1:0] mask_next
);
  function automatic logic [MW-1:0] apply_write(input logic [MW-1:0] cur,
                                                input acc_t k,
                                                input logic [MW-1:0] d);
    case (k)
      ACC_SET: return cur | d;
      ACC_CLR: return cur & ~d;
      default: return cur;
    endcase
  endfunction

  assign mask_next = apply_write(mask_q, acc, wbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_next;
  end

  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    acc == ACC_SET |=> (mask_q & $past(wbits)) == $past(wbits));
  a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    acc == ACC_CLR |=> (mask_q & $past(wbits)) == '0);
  a_r10_mask_idle: assert property (@(posedge clk) disable iff (!rst_n)
    acc == ACC_NONE |=> mask_q == $past(mask_q));
endmodule

// File: rtl/icr_flags.sv
module icr_flags
  import icr_pkg::*;
#(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  acc_t            acc,
  input  logic [NSRC-1:0] src_evt,
  output logic [NSRC-1:0] flags_q,
  output logic [NSRC-1:0] flags_next
);
  logic rd_clear;
  assign rd_clear = (acc == ACC_RD);

  // A clear from a read applies first, so same-cycle events survive it.
  assign flags_next = (rd_clear ? '0 : flags_q) | src_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_next;
  end

  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    src_evt != '0 |=> (flags_q & $past(src_evt)) == $past(src_evt));
  a_r6_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clear && src_evt == '0 |=> flags_q == '0);
  a_r7_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clear |=> flags_q == $past(src_evt));
endmodule

// File: rtl/icr_summary.sv
module icr_summary
  import icr_pkg::*;
#(
  parameter int NSRC = 5,
  parameter int MW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  acc_t            acc,
  input  logic [NSRC-1:0] src_evt,
  input  logic [NSRC-1:0] flags_next,
  input  logic [MW-1:0]   mask_q,
  input  logic [MW-1:0]   mask_next,
  output logic            sum_q
);
  localparam int PAD = MW - NSRC;

  function automatic logic any_enabled(input logic [NSRC-1:0] f,
                                       input logic [MW-1:0] m);
    return |({{PAD{1'b0}}, f} & m);
  endfunction

  logic evt_enabled, pend_enabled, sum_next;
  assign evt_enabled  = any_enabled(src_evt, mask_q);
  assign pend_enabled = (acc == ACC_SET) && any_enabled(flags_next, mask_next);
  assign sum_next     = ((acc == ACC_RD) ? 1'b0 : sum_q) | evt_enabled | pend_enabled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= 1'b0;
    else        sum_q <= sum_next;
  end

  a_r2_enabled_event: assert property (@(posedge clk) disable iff (!rst_n)
    evt_enabled |=> sum_q);
  a_r5_late_enable: assert property (@(posedge clk) disable iff (!rst_n)
    pend_enabled |=> sum_q);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q && acc != ACC_RD |=> sum_q);
endmodule

// File: rtl/icr_unit.sv
module icr_unit
  import icr_pkg::*;
#(
  parameter int NSRC     = 5,
  parameter int DW       = 8,
  parameter int AW       = 4,
  parameter int REG_ADDR = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            bus_sel,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq
);
  localparam int MW  = DW - 1;
  localparam int GAP = DW - 1 - NSRC;

  acc_t            acc;
  logic [NSRC-1:0] flags_q, flags_next;
  logic [MW-1:0]   mask_q, mask_next;
  logic            sum_q;

  icr_decode #(.AW(AW), .REG_ADDR(REG_ADDR)) u_dec (
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .wr_mode(bus_wdata[DW-1]), .acc(acc));

  icr_mask #(.MW(MW)) u_mask (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wbits(bus_wdata[MW-1:0]),
    .mask_q(mask_q), .mask_next(mask_next));

  icr_flags #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .acc(acc), .src_evt(src_evt),
    .flags_q(flags_q), .flags_next(flags_next));

  icr_summary #(.NSRC(NSRC), .MW(MW)) u_sum (
    .clk(clk), .rst_n(rst_n), .acc(acc), .src_evt(src_evt),
    .flags_next(flags_next), .mask_q(mask_q), .mask_next(mask_next),
    .sum_q(sum_q));

  assign irq       = sum_q;
  assign bus_rdata = (acc == ACC_RD) ? {sum_q, {GAP{1'b0}}, flags_q} : '0;

  a_r6_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    acc == ACC_RD && src_evt == '0 |=> !irq);
  a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    acc != ACC_RD |-> bus_rdata == '0);
endmodule

// File: tb/sim_icr_unit.sv
module sim_icr_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] src_evt = '0;
  logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int m_flags = 0, m_mask = 0, m_sum = 0;

  always #4 clk = ~clk;

  icr_unit u0 (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_sel(bus_sel),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = 0; m_mask = 0; m_sum = 0;
    end else begin
      int hit, rdh, setw, clrw, nf, nm, ns, e;
      e    = int'(src_evt);
      hit  = (bus_sel && bus_addr == 4'd13) ? 1 : 0;
      rdh  = hit && bus_rd;
      setw = hit && !bus_rd && bus_wr && bus_wdata[7];
      clrw = hit && !bus_rd && bus_wr && !bus_wdata[7];
      nf = (rdh ? 0 : m_flags) | e;
      nm = m_mask;
      if (setw) nm = m_mask | (bus_wdata & 8'h7f);
      if (clrw) nm = m_mask & ~(bus_wdata & 8'h7f);
      ns = rdh ? 0 : m_sum;
      if ((e & m_mask & 31) != 0) ns = 1;
      if (setw && (nf & nm & 31) != 0) ns = 1;
      m_flags = nf; m_mask = nm; m_sum = ns;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, then compare outputs
  task automatic step(input logic [4:0] e, input logic s, input logic [3:0] a,
                      input logic r, input logic w, input logic [7:0] d,
                      input string tag);
    int exp_rd;
    @(negedge clk);
    src_evt = e; bus_sel = s; bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
    #1;
    exp_rd = (s && a == 4'd13 && r) ? ((m_sum << 7) | m_flags) : 0;
    check({tag, " irq"}, int'(irq), m_sum);
    check({tag, " rdata"}, int'(bus_rdata), exp_rd);
  endtask

  task automatic idle(input string tag);        step(5'd0, 0, 4'd0, 0, 0, 8'h00, tag); endtask
  task automatic evt(input logic [4:0] e, input string tag); step(e, 0, 4'd0, 0, 0, 8'h00, tag); endtask
  task automatic rd(input string tag);          step(5'd0, 1, 4'd13, 1, 0, 8'h00, tag); endtask
  task automatic wr(input logic [7:0] d, input string tag); step(5'd0, 1, 4'd13, 0, 1, d, tag); endtask

  initial begin
    #100000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    check("R9 irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    rd("R9");
    idle("R9");

    // R1: each source latches with the mask clear
    for (int i = 0; i < 5; i++) begin
      evt(5'(1 << i), "R1");
      rd("R1");
      idle("R6");
    end
    evt(5'b10101, "R1"); evt(5'b00010, "R1"); rd("R1"); rd("R6");

    // R3/R2: enable timer A then fire it
    wr(8'h81, "R3"); evt(5'b00001, "R2");
    idle("R8"); evt(5'b00100, "R8"); wr(8'h01, "R8"); idle("R8");
    rd("R6"); idle("R6");

    // R5: pending timer B enabled later
    evt(5'b00010, "R5"); idle("R5"); wr(8'h82, "R5"); idle("R5"); rd("R5"); idle("R5");
    // R5: event in same cycle as enabling write
    step(5'b01000, 1, 4'd13, 0, 1, 8'h88, "R5"); idle("R5"); rd("R5");

    // R4: clear mask bits, events no longer raise irq
    wr(8'h0B, "R4"); evt(5'b01011, "R4"); idle("R4"); rd("R4"); idle("R4");

    // R7: event coincides with read
    wr(8'h84, "R7");
    step(5'b00100, 1, 4'd13, 1, 0, 8'h00, "R7"); idle("R7"); rd("R7");
    evt(5'b10000, "R7");
    step(5'b00001, 1, 4'd13, 1, 0, 8'h00, "R7"); idle("R7"); rd("R7");

    // R10: wrong address and deselected accesses
    step(5'd0, 1, 4'd12, 0, 1, 8'hFF, "R10"); evt(5'b00011, "R10");
    step(5'd0, 0, 4'd13, 1, 0, 8'h00, "R10");
    step(5'd0, 1, 4'd12, 1, 0, 8'h00, "R10");
    step(5'd0, 0, 4'd13, 0, 1, 8'h00, "R10");
    evt(5'b00100, "R10"); rd("R10"); idle("R10");

    // R9: reset mid-run
    wr(8'hFF, "R9"); evt(5'b11111, "R9");
    @(negedge clk); rst_n = 1'b0; #1;
    check("R9 irq after reset", int'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    evt(5'b00001, "R9"); rd("R9"); idle("R9");

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0: rd("R6");
        3'd1: wr({lfsr[3], 2'b00, lfsr[8:4]}, "R3");
        3'd2: step(lfsr[9:5], 1, 4'd13, 1, 0, 8'h00, "R7");
        default: evt(lfsr[7:3] & lfsr[12:8], "R8");
      endcase
    end
    rd("R6"); idle("R6");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule